// File: doc/BRIEF.md
# SIMD Control Register Load Checker

This block owns the 32-bit control and status word of a SIMD floating-point unit and carries out the instruction that loads that word from a 32-bit memory operand. The front end hands it the opcode bytes, the mode and reg fields of the ModRM byte, a LOCK-prefix flag, the effective address that was resolved from the r/m field, and the 32 bits fetched from that address. With these come the machine state the instruction depends on: the emulation, task-switched, OS-SIMD-support and alignment-check-enable control bits, a SIMD feature-present bit, the current privilege level and the processor mode.

For each recognised load, the block either writes the new value into the register or reports exactly one fault code. Lower-priority checks are masked whenever a higher-priority fault applies. One cycle after the load is presented, a done pulse appears together with the fault code, and the register shows its new value at that point.

Separately, the block compares the six exception flags of the register with their mask bits and reports whether any unmasked flag is pending. A later SIMD arithmetic operation reports which exception classes it produces. When one of those classes is pending, the block raises the SIMD exception for that operation. Loading a value that unmasks a flag which is already set never faults by itself.

Top module: `simd_csr_loader`

## Requirements
- R1: A load is recognised only when `load_valid` is 1, `op_byte0` is 0x0F, `op_byte1` is 0xAE, `modrm_reg` is 2 and `modrm_mod` is not 3. Any other input gives no `done_valid` pulse and leaves `csr_value` unchanged.
- R2: While reset is asserted and in the first cycle after it is released, `csr_value` is 0x00001F80 and `done_valid` is 0.
- R3: The block reports fault code 1 (invalid opcode) when any of these holds: `cr_emu` is 1, `cr_osfx` is 0, `feat_simd` is 0, or `lock_pfx` is 1.
- R4: The block reports fault code 2 (device not available) when `cr_ts` is 1.
- R5: The block reports fault code 3 (alignment) when `cr_acen` is 1 and `op_addr[1:0]` is not 0, provided the privilege condition for the mode is met. The `cpu_mode` encoding is 0 real, 1 protected, 2 virtual-8086, 3 64-bit. In modes 1 and 3 the fault also needs `cpl` to be 3. In mode 2 any `cpl` qualifies. Mode 0 never raises this fault.
- R6: In real mode (`cpu_mode` 0), the block reports fault code 4 (general protection) when `op_addr` is above 0xFFFC, that is, when some byte of the 4-byte operand lies past 0xFFFF.
- R7: The block reports fault code 4 when `load_data` has a 1 in any bit outside the valid mask. By default bits 31:16 are reserved.
- R8: When several faults apply, only the highest-priority one is reported. The order is code 1, then code 2, then the address checks (codes 3 and 6's code 4), then the reserved-bit code 4. Code 0 means the load committed.
- R9: A recognised load with no fault gives `done_valid`=1 and `fault_code`=0 in the next cycle, and `csr_value` equals `load_data` in that same cycle.
- R10: A recognised load that faults leaves `csr_value` unchanged.
- R11: `deferred_pending` is the OR over i=0..5 of (bit i AND NOT bit 7+i) of `csr_value`. A load that unmasks a set flag still commits with code 0.
- R12: `simd_exc` is 1 when `simd_op_valid` is 1 and `simd_op_class` shares a bit with the pending classes of the current register value. A load committing in the same cycle does not affect this result until the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_valid | input | 1 | A decoded instruction is presented |
| op_byte0 | input | 8 | First opcode byte |
| op_byte1 | input | 8 | Second opcode byte |
| modrm_mod | input | 2 | ModRM mode field |
| modrm_reg | input | 3 | ModRM reg field |
| lock_pfx | input | 1 | LOCK prefix present |
| op_addr | input | ADDR_W | Effective address of the operand |
| load_data | input | 32 | Operand value fetched from memory |
| cr_emu | input | 1 | Emulation control bit |
| cr_ts | input | 1 | Task-switched control bit |
| cr_osfx | input | 1 | OS SIMD support bit |
| cr_acen | input | 1 | Alignment checking enabled |
| feat_simd | input | 1 | SIMD feature present |
| cpl | input | 2 | Current privilege level |
| cpu_mode | input | 2 | 0 real, 1 protected, 2 virtual-8086, 3 64-bit |
| simd_op_valid | input | 1 | A SIMD operation reports exceptions |
| simd_op_class | input | 6 | Exception classes reported by that operation |
| done_valid | output | 1 | Recognised load finished (one cycle later) |
| fault_code | output | 3 | 0 none, 1 invalid opcode, 2 device n/a, 3 alignment, 4 general protection |
| csr_value | output | 32 | Current register value (store-style read) |
| deferred_pending | output | 1 | Some flag is set and unmasked |
| simd_exc | output | 1 | SIMD exception raised for the current operation |

## Verification
Two functions can land on the same clock edge: a load that changes the mask bits, and a SIMD operation that reports an exception class. The bench triggers this by driving a load and an operation together. In one case the load masks a pending class that the operation reports. In the other it unmasks a class that the operation reports. The exception output is sampled before and after that edge. The result must follow the old register value before the edge and the newly committed value afterwards.

// File: rtl/simd_csr_pkg.sv
package simd_csr_pkg;

    localparam int       CSR_W      = 32;
    localparam int       NCLASS     = 6;
    localparam int       FLAG_LSB   = 0;
    localparam int       MASK_LSB   = 7;
    localparam int       OPND_BYTES = 4;
    localparam int       REAL_LIMIT = 32'h0000_FFFF;

    localparam logic [7:0] OPC_ESC = 8'h0F;
    localparam logic [7:0] OPC_GRP = 8'hAE;
    localparam logic [2:0] REG_SEL = 3'd2;
    localparam logic [1:0] MOD_REG = 2'b11;

    typedef enum logic [2:0] {
        FC_NONE = 3'd0,
        FC_UD   = 3'd1,
        FC_NM   = 3'd2,
        FC_AC   = 3'd3,
        FC_GP   = 3'd4
    } fault_e;

    typedef enum logic [1:0] {
        MD_REAL = 2'd0,
        MD_PROT = 2'd1,
        MD_V86  = 2'd2,
        MD_LONG = 2'd3
    } mode_e;

    typedef struct packed {
        logic emu;
        logic ts;
        logic osfx;
        logic acen;
        logic feat;
        logic lock;
    } ctl_t;

    typedef struct packed {
        logic ud;
        logic nm;
        logic addr_gp;
        logic align;
        logic rsv;
    } fault_set_t;

    function automatic fault_e pick_fault(input fault_set_t f);
        if (f.ud)           return FC_UD;
        else if (f.nm)      return FC_NM;
        else if (f.addr_gp) return FC_GP;
        else if (f.align)   return FC_AC;
        else if (f.rsv)     return FC_GP;
        else                return FC_NONE;
    endfunction

endpackage

// File: rtl/simd_csr_decode.sv
module simd_csr_decode
    import simd_csr_pkg::*;
(
    input  logic       valid,
    input  logic [7:0] b0,
    input  logic [7:0] b1,
    input  logic [1:0] mod_f,
    input  logic [2:0] reg_f,
    output logic       hit
);
    logic opc_ok;
    logic mem_form;

    assign opc_ok   = (b0 == OPC_ESC) && (b1 == OPC_GRP) && (reg_f == REG_SEL);
    assign mem_form = (mod_f != MOD_REG);
    assign hit      = valid && opc_ok && mem_form;
endmodule

// File: rtl/simd_csr_fault_chk.sv
module simd_csr_fault_chk
    import simd_csr_pkg::*;
#(
    parameter int                ADDR_W     = 32,
    parameter logic [CSR_W-1:0]  VALID_MASK = 32'h0000_FFFF
)(
    input  ctl_t              ctl,
    input  logic [1:0]        cpl,
    input  mode_e             mode,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CSR_W-1:0]  data,
    output fault_e            code
);
    localparam int                ALIGN_BITS = $clog2(OPND_BYTES);
    localparam logic [ADDR_W-1:0] REAL_LAST  = ADDR_W'(REAL_LIMIT - (OPND_BYTES - 1));
    localparam logic [1:0]        USER_CPL   = 2'd3;

    fault_set_t f;
    logic       misaligned;
    logic       priv_ok;

    assign misaligned = (addr[ALIGN_BITS-1:0] != '0);

    always_comb begin
        unique case (mode)
            MD_PROT, MD_LONG: priv_ok = (cpl == USER_CPL);
            MD_V86:           priv_ok = 1'b1;
            default:          priv_ok = 1'b0;
        endcase
    end

    always_comb begin
        f.ud      = ctl.emu || !ctl.osfx || !ctl.feat || ctl.lock;
        f.nm      = ctl.ts;
        f.addr_gp = (mode == MD_REAL) && (addr > REAL_LAST);
        f.align   = ctl.acen && misaligned && priv_ok;
        f.rsv     = |(data & ~VALID_MASK);
    end

    assign code = pick_fault(f);
endmodule

// File: rtl/simd_csr_reg.sv
module simd_csr_reg
    import simd_csr_pkg::*;
#(
    parameter logic [CSR_W-1:0] VALID_MASK = 32'h0000_FFFF,
    parameter logic [CSR_W-1:0] RESET_VAL  = 32'h0000_1F80
)(
    input  logic             clk,
    input  logic             rst,
    input  logic             hit,
    input  fault_e           code,
    input  logic [CSR_W-1:0] wdata,
    output logic [CSR_W-1:0] csr,
    output logic             done,
    output fault_e           done_code
);
    logic we;

    assign we = hit && (code == FC_NONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            csr       <= RESET_VAL & VALID_MASK;
            done      <= 1'b0;
            done_code <= FC_NONE;
        end else begin
            done      <= hit;
            done_code <= hit ? code : FC_NONE;
            if (we) begin
                csr <= wdata;
            end
        end
    end
endmodule

// File: rtl/simd_csr_pend.sv
module simd_csr_pend
    import simd_csr_pkg::*;
(
    input  logic [CSR_W-1:0]  csr,
    input  logic              op_valid,
    input  logic [NCLASS-1:0] op_class,
    output logic              pending,
    output logic              exc
);
    logic [NCLASS-1:0] pv;
    logic [NCLASS-1:0] match;

    for (genvar i = 0; i < NCLASS; i++) begin : g_class
        assign pv[i]    = csr[FLAG_LSB + i] && !csr[MASK_LSB + i];
        assign match[i] = pv[i] && op_class[i];
    end

    assign pending = |pv;
    assign exc     = op_valid && (|match);
endmodule

// File: rtl/simd_csr_loader.sv
module simd_csr_loader
    import simd_csr_pkg::*;
#(
    parameter int               ADDR_W     = 32,
    parameter logic [CSR_W-1:0] VALID_MASK = 32'h0000_FFFF,
    parameter logic [CSR_W-1:0] RESET_VAL  = 32'h0000_1F80
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              load_valid,
    input  logic [7:0]        op_byte0,
    input  logic [7:0]        op_byte1,
    input  logic [1:0]        modrm_mod,
    input  logic [2:0]        modrm_reg,
    input  logic              lock_pfx,
    input  logic [ADDR_W-1:0] op_addr,
    input  logic [31:0]       load_data,
    input  logic              cr_emu,
    input  logic              cr_ts,
    input  logic              cr_osfx,
    input  logic              cr_acen,
    input  logic              feat_simd,
    input  logic [1:0]        cpl,
    input  logic [1:0]        cpu_mode,
    input  logic              simd_op_valid,
    input  logic [5:0]        simd_op_class,
    output logic              done_valid,
    output logic [2:0]        fault_code,
    output logic [31:0]       csr_value,
    output logic              deferred_pending,
    output logic              simd_exc
);
    logic   hit;
    ctl_t   ctl;
    fault_e code_now;
    fault_e code_q;

    assign ctl = '{emu: cr_emu, ts: cr_ts, osfx: cr_osfx, acen: cr_acen,
                   feat: feat_simd, lock: lock_pfx};

    simd_csr_decode u_dec (
        .valid (load_valid),
        .b0    (op_byte0),
        .b1    (op_byte1),
        .mod_f (modrm_mod),
        .reg_f (modrm_reg),
        .hit   (hit)
    );

    simd_csr_fault_chk #(
        .ADDR_W     (ADDR_W),
        .VALID_MASK (VALID_MASK)
    ) u_chk (
        .ctl  (ctl),
        .cpl  (cpl),
        .mode (mode_e'(cpu_mode)),
        .addr (op_addr),
        .data (load_data),
        .code (code_now)
    );

    simd_csr_reg #(
        .VALID_MASK (VALID_MASK),
        .RESET_VAL  (RESET_VAL)
    ) u_reg (
        .clk       (clk),
        .rst       (rst),
        .hit       (hit),
        .code      (code_now),
        .wdata     (load_data),
        .csr       (csr_value),
        .done      (done_valid),
        .done_code (code_q)
    );

    simd_csr_pend u_pend (
        .csr      (csr_value),
        .op_valid (simd_op_valid),
        .op_class (simd_op_class),
        .pending  (deferred_pending),
        .exc      (simd_exc)
    );

    assign fault_code = code_q;
endmodule

// File: rtl/simd_csr_loader_sva.sv
module simd_csr_loader_sva
    import simd_csr_pkg::*;
#(
    parameter logic [31:0] VALID_MASK = 32'h0000_FFFF,
    parameter logic [31:0] RESET_VAL  = 32'h0000_1F80
)(
    input logic        clk,
    input logic        rst,
    input logic        hit,
    input logic        lock_pfx,
    input logic        cr_ts,
    input logic        done_valid,
    input logic [2:0]  fault_code,
    input logic [31:0] csr_value,
    input logic        deferred_pending,
    input logic        simd_exc,
    input logic        simd_op_valid
);
    assert_reset_value_R2: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (csr_value == (RESET_VAL & VALID_MASK)) && !done_valid);

    assert_done_needs_hit_R1: assert property (@(posedge clk) disable iff (rst)
        done_valid |-> $past(hit));

    assert_lock_is_ud_R3: assert property (@(posedge clk) disable iff (rst)
        hit && lock_pfx |=> done_valid && (fault_code == 3'd1));

    assert_ts_faults_R4: assert property (@(posedge clk) disable iff (rst)
        hit && cr_ts |=> done_valid && (fault_code == 3'd1 || fault_code == 3'd2));

    assert_no_reserved_R7: assert property (@(posedge clk) disable iff (rst)
        (csr_value & ~VALID_MASK) == 32'h0);

    assert_code_range_R8: assert property (@(posedge clk) disable iff (rst)
        done_valid |-> fault_code <= 3'd4);

    assert_change_only_clean_R9: assert property (@(posedge clk) disable iff (rst)
        (csr_value != $past(csr_value)) |-> done_valid && (fault_code == 3'd0));

    assert_fault_keeps_R10: assert property (@(posedge clk) disable iff (rst)
        done_valid && (fault_code != 3'd0) |-> $stable(csr_value));

    assert_exc_needs_pending_R12: assert property (@(posedge clk) disable iff (rst)
        simd_exc |-> simd_op_valid && deferred_pending);
endmodule

bind simd_csr_loader simd_csr_loader_sva #(
    .VALID_MASK (VALID_MASK),
    .RESET_VAL  (RESET_VAL)
) u_sva (
    .clk              (clk),
    .rst              (rst),
    .hit              (hit),
    .lock_pfx         (lock_pfx),
    .cr_ts            (cr_ts),
    .done_valid       (done_valid),
    .fault_code       (fault_code),
    .csr_value        (csr_value),
    .deferred_pending (deferred_pending),
    .simd_exc         (simd_exc),
    .simd_op_valid    (simd_op_valid)
);

// File: tb/simd_csr_loader_test.sv
module simd_csr_loader_test;

    logic        clk = 1'b0;
    logic        rst;
    logic        load_valid;
    logic [7:0]  op_byte0, op_byte1;
    logic [1:0]  modrm_mod;
    logic [2:0]  modrm_reg;
    logic        lock_pfx;
    logic [31:0] op_addr;
    logic [31:0] load_data;
    logic        cr_emu, cr_ts, cr_osfx, cr_acen, feat_simd;
    logic [1:0]  cpl, cpu_mode;
    logic        simd_op_valid;
    logic [5:0]  simd_op_class;
    logic        done_valid;
    logic [2:0]  fault_code;
    logic [31:0] csr_value;
    logic        deferred_pending;
    logic        simd_exc;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    logic [31:0] model;

    always #4 clk = ~clk;

    simd_csr_loader uut (
        .clk(clk), .rst(rst), .load_valid(load_valid),
        .op_byte0(op_byte0), .op_byte1(op_byte1),
        .modrm_mod(modrm_mod), .modrm_reg(modrm_reg),
        .lock_pfx(lock_pfx), .op_addr(op_addr), .load_data(load_data),
        .cr_emu(cr_emu), .cr_ts(cr_ts), .cr_osfx(cr_osfx), .cr_acen(cr_acen),
        .feat_simd(feat_simd), .cpl(cpl), .cpu_mode(cpu_mode),
        .simd_op_valid(simd_op_valid), .simd_op_class(simd_op_class),
        .done_valid(done_valid), .fault_code(fault_code), .csr_value(csr_value),
        .deferred_pending(deferred_pending), .simd_exc(simd_exc)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected<=150000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [2:0] ref_code(input logic [5:0] c, input logic [1:0] m,
                                            input logic [1:0] p, input logic [31:0] a,
                                            input logic [31:0] d);
        logic emu, ts, osfx, feat, lck, acen, priv;
        emu = c[0]; ts = c[1]; osfx = c[2]; feat = c[3]; lck = c[4]; acen = c[5];
        priv = (m == 2'd2) || ((m == 2'd1 || m == 2'd3) && p == 2'd3);
        if (emu || !osfx || !feat || lck)           return 3'd1;
        if (ts)                                     return 3'd2;
        if (m == 2'd0 && a > 32'h0000_FFFC)         return 3'd4;
        if (acen && a[1:0] != 2'b00 && priv)        return 3'd3;
        if (d[31:16] != 16'h0)                      return 3'd4;
        return 3'd0;
    endfunction

    function automatic logic ref_pend(input logic [31:0] v);
        return |(v[5:0] & ~v[12:7]);
    endfunction

    task automatic clean_ctl();
        cr_emu = 0; cr_ts = 0; cr_osfx = 1; cr_acen = 0; feat_simd = 1; lock_pfx = 0;
        cpl = 2'd0; cpu_mode = 2'd1; op_addr = 32'h1000;
    endtask

    task automatic set_op(input logic v);
        load_valid = v; op_byte0 = 8'h0F; op_byte1 = 8'hAE; modrm_mod = 2'b00; modrm_reg = 3'd2;
    endtask

    initial begin
        rst = 1; set_op(0); clean_ctl(); load_data = 0;
        simd_op_valid = 0; simd_op_class = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        chk("R2 csr reset", csr_value, 32'h1F80);
        chk("R2 done reset", {31'h0, done_valid}, 32'h0);
        chk("R11 pending at reset", {31'h0, deferred_pending}, 32'h0);
        @(negedge clk);
        chk("R2 csr after release", csr_value, 32'h1F80);
        model = 32'h1F80;

        for (int k = 0; k < 5; k++) begin
            set_op(1); load_data = 32'h0000_1234;
            case (k)
                0: op_byte0 = 8'h0E;
                1: op_byte1 = 8'hAF;
                2: modrm_reg = 3'd3;
                3: modrm_mod = 2'b11;
                default: load_valid = 0;
            endcase
            @(negedge clk);
            chk("R1 ignored no done", {31'h0, done_valid}, 32'h0);
            chk("R1 ignored csr", csr_value, model);
        end
        set_op(1); load_data = 32'h0000_1234;
        @(negedge clk);
        chk("R1 recognised done", {31'h0, done_valid}, 32'h1);
        chk("R9 clean commit", csr_value, 32'h0000_1234);
        model = 32'h0000_1234;

        for (int c = 0; c < 64; c++)
            for (int m = 0; m < 4; m++)
                for (int p = 0; p < 2; p++)
                    for (int a = 0; a < 4; a++)
                        for (int d = 0; d < 2; d++) begin
                            logic [31:0] adr, dat;
                            logic [2:0]  ec;
                            string       tg;
                            adr = (a == 0) ? 32'h1000 : (a == 1) ? 32'h1002 :
                                  (a == 2) ? 32'hFFFC : 32'hFFFD;
                            dat = {16'h0, 16'(c * 16'h9E37 + m * 16'h0111) ^ 16'h1F80};
                            if (d == 1) dat = dat | (32'h1 << (16 + ((c + a) % 16)));
                            set_op(1);
                            cr_emu = c[0]; cr_ts = c[1]; cr_osfx = c[2]; feat_simd = c[3];
                            lock_pfx = c[4]; cr_acen = c[5];
                            cpu_mode = 2'(m); cpl = (p == 1) ? 2'd3 : 2'd0;
                            op_addr = adr; load_data = dat;
                            ec = ref_code(6'(c), 2'(m), cpl, adr, dat);
                            @(negedge clk);
                            case (ec)
                                3'd1: tg = "R3 invalid-opcode code";
                                3'd2: tg = "R4 device code";
                                3'd3: tg = "R5 alignment code";
                                3'd4: tg = (m == 0 && adr > 32'hFFFC) ? "R6 real limit code"
                                                                      : "R7 reserved code";
                                default: tg = "R8 no-fault code";
                            endcase
                            chk(tg, {29'h0, fault_code}, {29'h0, ec});
                            chk("R9 done pulse", {31'h0, done_valid}, 32'h1);
                            if (ec == 3'd0) model = dat;
                            chk(ec == 3'd0 ? "R9 committed value" : "R10 faulted keeps value",
                                csr_value, model);
                            chk("R11 pending", {31'h0, deferred_pending}, {31'h0, ref_pend(model)});
                        end

        clean_ctl(); set_op(1); load_data = 32'h0000_1F01;
        @(negedge clk);
        chk("R11 unmask commits", {29'h0, fault_code}, 32'h0);
        chk("R11 unmask pending", {31'h0, deferred_pending}, 32'h1);
        set_op(0);
        simd_op_valid = 1; simd_op_class = 6'b000010; #1;
        chk("R12 other class", {31'h0, simd_exc}, 32'h0);
        simd_op_class = 6'b000001; #1;
        chk("R12 matching class", {31'h0, simd_exc}, 32'h1);
        simd_op_valid = 0; #1;
        chk("R12 no op", {31'h0, simd_exc}, 32'h0);
        @(negedge clk);

        simd_op_valid = 1; simd_op_class = 6'b000001;
        set_op(1); load_data = 32'h0000_1F80; #1;
        chk("R12 same cycle uses old value", {31'h0, simd_exc}, 32'h1);
        @(negedge clk);
        set_op(0); #1;
        chk("R12 masked after commit", {31'h0, simd_exc}, 32'h0);
        chk("R9 masking commit", csr_value, 32'h0000_1F80);

        simd_op_class = 6'b000010;
        set_op(1); load_data = 32'h0000_1E82; #1;
        chk("R12 same cycle before unmask", {31'h0, simd_exc}, 32'h0);
        @(negedge clk);
        set_op(0); #1;
        chk("R12 unmasked after commit", {31'h0, simd_exc}, 32'h1);
        simd_op_valid = 0;
        @(negedge clk);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule